// File: doc/BRIEF.md
# Sign-Select Dot-Product Engine for Binary and Ternary Weights

This block forms the dot product of a stream of signed 8-bit activations with a stream of one- or two-bit weights and needs no multiplier per element. Each weight code only decides whether its activation is added to a running sum, subtracted from it, or left out. Every weight in a vector shares one unsigned magnitude. That magnitude is applied once, by a single multiply on the finished sum, so the block emits one scaled result per vector.

Activation/weight pairs arrive one per cycle while `in_valid` is high. There is no backpressure, and gaps between beats are allowed. `in_last` marks the final beat of a vector. On the next cycle the engine multiplies the signed sum by the scale that was presented with that final beat. It then raises `out_valid` for one cycle, with the product on `out_result`. The weight format is chosen on each beat by `mode`. In binary mode (`mode`=0) a weight is one bit. In ternary mode (`mode`=1) a weight is a two-bit code that can also mean zero.

Top module: `bdot_engine`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls, `out_valid` is 0 and `out_result` is 0.
- R2: In binary mode (`mode`=0), `in_wgt[0]`=1 adds the activation to the sum and `in_wgt[0]`=0 subtracts it. `in_wgt[1]` has no effect in this mode.
- R3: In ternary mode (`mode`=1), code 2'b01 adds the activation and code 2'b11 subtracts it.
- R4: In ternary mode, codes 2'b00 and 2'b10 are zero weights. A beat carrying either code leaves the running sum unchanged.
- R5: The first accepted beat after reset, or after a beat flagged last, starts a new sum from zero. Earlier vectors never leak into a later result.
- R6: The clock edge that accepts a beat with `in_valid`=1 and `in_last`=1 is edge E. `out_valid` is high only in the cycle after edge E+1, so each vector produces exactly one pulse.
- R7: `out_result` equals the signed sum times `scale`, where `scale` is read as unsigned and sampled on the last beat. The product is carried at the full 36-bit signed width, and `scale` on other beats is ignored.
- R8: Cycles with `in_valid`=0 change neither the sum nor the outputs, and a vector may contain idle gaps.
- R9: `out_result` keeps its value in every cycle where `out_valid` is low.
- R10: A new vector may start on the cycle right after a last beat, and single-beat vectors may follow one another. Each one yields its own correct pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | Weight format of this beat: 0 binary, 1 ternary |
| in_valid | input | 1 | A pair is presented this cycle |
| in_last | input | 1 | This pair ends the vector |
| in_act | input | 8 | Signed activation |
| in_wgt | input | 2 | Weight code (binary uses bit 0) |
| scale | input | 16 | Unsigned shared magnitude, sampled with the last beat |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 36 | Signed scaled dot product |

## Verification
The bench runs five kinds of input:
- Binary vectors with random junk in the unused weight bit. These show whether the engine decodes the right bit.
- Ternary vectors mixing all four codes, plus one vector made only of zero codes. These separate adding, subtracting and skipping.
- Vectors with idle gaps and a scale that changes on every beat. These show that idle cycles are ignored and that the scale is taken from the last beat.
- Back-to-back vectors of one beat and of several beats. These expose sums that fail to clear and pulses that are missed.
- Extreme activations with the largest and the zero scale. These check the sign and the width of the final product.

A behavioural model predicts `out_valid` and `out_result` for every cycle.

// File: rtl/bdot_pkg.sv
package bdot_pkg;

  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_TER = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } wact_e;

endpackage

// File: rtl/bdot_weight_decode.sv
module bdot_weight_decode
  import bdot_pkg::*;
(
  input  logic       mode,
  input  logic [1:0] wgt,
  output wact_e      action
);

  always_comb begin
    if (mode == MODE_BIN) begin
      action = wgt[0] ? ACT_ADD : ACT_SUB;
    end else begin
      unique case (wgt)
        2'b01:   action = ACT_ADD;
        2'b11:   action = ACT_SUB;
        default: action = ACT_SKIP;
      endcase
    end
  end

  always_comb begin
    if (mode == MODE_BIN) begin
      AST_BIN_NEVER_SKIPS: assert (action != ACT_SKIP); // R2
    end
  end

endmodule

// File: rtl/bdot_sign_select.sv
module bdot_sign_select
  import bdot_pkg::*;
#(
  parameter int ACT_W = 8,
  parameter int ACC_W = 20
) (
  input  logic signed [ACT_W-1:0] act,
  input  wact_e                   action,
  output logic signed [ACC_W-1:0] term
);

  localparam int EXT_W = ACC_W - ACT_W;

  logic signed [ACC_W-1:0] widened;

  assign widened = {{EXT_W{act[ACT_W-1]}}, act};

  always_comb begin
    unique case (action)
      ACT_ADD: term = widened;
      ACT_SUB: term = -widened;
      default: term = '0;
    endcase
  end

endmodule

// File: rtl/bdot_accum.sv
module bdot_accum #(
  parameter int ACC_W   = 20,
  parameter int SCALE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    beat,
  input  logic                    last,
  input  logic signed [ACC_W-1:0] term,
  input  logic [SCALE_W-1:0]      scale,
  output logic signed [ACC_W-1:0] acc,
  output logic                    done,
  output logic [SCALE_W-1:0]      scale_q,
  output logic                    open
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      done    <= 1'b0;
      scale_q <= '0;
      open    <= 1'b0;
    end else begin
      done <= beat && last;
      if (beat) begin
        acc  <= open ? (acc + term) : term;
        open <= !last;
        if (last) begin
          scale_q <= scale;
        end
      end
    end
  end

endmodule

// File: rtl/bdot_scale_stage.sv
module bdot_scale_stage #(
  parameter int ACC_W   = 20,
  parameter int SCALE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          done,
  input  logic signed [ACC_W-1:0]       acc,
  input  logic [SCALE_W-1:0]            scale_q,
  output logic                          out_valid,
  output logic signed [ACC_W+SCALE_W-1:0] out_result
);

  localparam int RES_W  = ACC_W + SCALE_W;
  localparam int PROD_W = RES_W + 1;

  logic signed [SCALE_W:0]  scale_s;
  logic signed [PROD_W-1:0] product;

  assign scale_s = $signed({1'b0, scale_q});
  assign product = acc * scale_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= done;
      if (done) begin
        out_result <= product[RES_W-1:0];
      end
    end
  end

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result)); // R9

endmodule

// File: rtl/bdot_engine.sv
module bdot_engine
  import bdot_pkg::*;
#(
  parameter int ACT_W   = 8,
  parameter int ACC_W   = 20,
  parameter int SCALE_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            mode,
  input  logic                            in_valid,
  input  logic                            in_last,
  input  logic signed [ACT_W-1:0]         in_act,
  input  logic [1:0]                      in_wgt,
  input  logic [SCALE_W-1:0]              scale,
  output logic                            out_valid,
  output logic signed [ACC_W+SCALE_W-1:0] out_result
);

  wact_e                   action;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc;
  logic [SCALE_W-1:0]      scale_q;
  logic                    done;
  logic                    open;

  bdot_weight_decode u_decode (
    .mode   (mode),
    .wgt    (in_wgt),
    .action (action)
  );

  bdot_sign_select #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_select (
    .act    (in_act),
    .action (action),
    .term   (term)
  );

  bdot_accum #(.ACC_W(ACC_W), .SCALE_W(SCALE_W)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .beat    (in_valid),
    .last    (in_last),
    .term    (term),
    .scale   (scale),
    .acc     (acc),
    .done    (done),
    .scale_q (scale_q),
    .open    (open)
  );

  bdot_scale_stage #(.ACC_W(ACC_W), .SCALE_W(SCALE_W)) u_scale (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .acc        (acc),
    .scale_q    (scale_q),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0)); // R1

  AST_SKIP_KEEPS_SUM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && open && action == ACT_SKIP) |=> acc == $past(acc)); // R4

  AST_FIRST_BEAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !open && action == ACT_SKIP) |=> acc == '0); // R5

  AST_IDLE_KEEPS_SUM: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(acc)); // R8

  AST_PULSE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_last, 2)); // R6

endmodule

// File: tb/tb_bdot_engine.sv
module tb_bdot_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic signed [7:0] in_act = '0;
  logic [1:0]  in_wgt = '0;
  logic [15:0] scale = '0;
  logic        out_valid;
  logic signed [35:0] out_result;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // model state
  longint m_sum = 0;
  bit     m_open = 1'b0;
  bit     m_pend = 1'b0;
  longint m_pend_val = 0;
  bit     m_valid = 1'b0;
  longint m_result = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bdot_engine dut (
    .clk(clk), .rst(rst), .mode(mode), .in_valid(in_valid),
    .in_last(in_last), .in_act(in_act), .in_wgt(in_wgt), .scale(scale),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic int wval(input logic md, input logic [1:0] w);
    if (!md) return w[0] ? 1 : -1;
    if (w == 2'b01) return 1;
    if (w == 2'b11) return -1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sum = 0; m_open = 0; m_pend = 0; m_valid = 0; m_result = 0;
    end else begin
      m_valid = m_pend;
      if (m_pend) m_result = m_pend_val;
      m_pend = 0;
      if (in_valid) begin
        if (!m_open) m_sum = 0;
        m_sum = m_sum + longint'(wval(mode, in_wgt)) * longint'(in_act);
        m_open = !in_last;
        if (in_last) begin
          m_pend = 1;
          m_pend_val = m_sum * longint'(scale);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL %s out_valid actual=%0b expected=%0b t=%0t", cur_req, out_valid, m_valid, $time);
      end
      checks++;
      if (out_result !== m_result[35:0]) begin
        errors++;
        $display("FAIL %s out_result actual=%0d expected=%0d t=%0t", cur_req, out_result, m_result, $time);
      end
    end
  end

  task automatic beat(input logic md, input logic signed [7:0] a,
                      input logic [1:0] w, input logic lst, input logic [15:0] s);
    mode = md; in_valid = 1'b1; in_act = a; in_wgt = w; in_last = lst; scale = s;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    scale = 16'($urandom);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_last = 1'b0;
    in_act = 8'($urandom); in_wgt = 2'($urandom);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);

    cur_req = "R2"; // binary, junk in bit 1
    for (int i = 0; i < 6; i++)
      beat(1'b0, 8'($urandom), {1'($urandom), 1'(i % 3 == 0)}, i == 5, 16'd3);
    idle(3);

    cur_req = "R3"; // ternary add/sub
    beat(1'b1, 8'sd100, 2'b01, 1'b0, 16'd1);
    beat(1'b1, -8'sd20, 2'b11, 1'b0, 16'd1);
    beat(1'b1, 8'sd7,   2'b11, 1'b1, 16'd5);
    idle(3);

    cur_req = "R4"; // zero codes only, then mixed
    beat(1'b1, 8'sd90,  2'b00, 1'b0, 16'd9);
    beat(1'b1, -8'sd90, 2'b10, 1'b1, 16'd9);
    idle(2);
    beat(1'b1, 8'sd11,  2'b01, 1'b0, 16'd2);
    beat(1'b1, 8'sd50,  2'b10, 1'b0, 16'd2);
    beat(1'b1, 8'sd50,  2'b00, 1'b1, 16'd2);
    idle(3);

    cur_req = "R8"; // gaps, changing scale
    beat(1'b0, 8'sd10, 2'b01, 1'b0, 16'd100);
    idle(4);
    beat(1'b1, 8'sd3, 2'b11, 1'b0, 16'd200);
    idle(1);
    beat(1'b0, -8'sd4, 2'b00, 1'b1, 16'd7);
    idle(3);

    cur_req = "R10"; // back to back, single-beat vectors
    beat(1'b0, 8'sd5,  2'b01, 1'b1, 16'd4);
    beat(1'b0, 8'sd6,  2'b00, 1'b1, 16'd4);
    beat(1'b1, 8'sd9,  2'b01, 1'b1, 16'd4);
    beat(1'b1, 8'sd1,  2'b01, 1'b0, 16'd4);
    beat(1'b1, 8'sd2,  2'b01, 1'b1, 16'd4);
    cur_req = "R5";
    beat(1'b1, 8'sd1,  2'b00, 1'b1, 16'd4);
    idle(3);

    cur_req = "R7"; // extremes
    for (int i = 0; i < 40; i++)
      beat(1'b0, -8'sd128, 2'b01, i == 39, 16'hFFFF);
    idle(2);
    for (int i = 0; i < 40; i++)
      beat(1'b0, -8'sd128, 2'b00, i == 39, 16'hFFFF);
    idle(2);
    beat(1'b1, 8'sd127, 2'b01, 1'b1, 16'd0);
    idle(3);

    cur_req = "R9"; // random mixed traffic
    for (int v = 0; v < 60; v++) begin
      int len = 1 + int'($urandom % 12);
      for (int i = 0; i < len; i++) begin
        beat(1'($urandom), 8'($urandom), 2'($urandom), i == len - 1, 16'($urandom));
        if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
      end
      if (v % 2 == 0) idle(int'($urandom % 3));
    end
    idle(4);

    cur_req = "R1";
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule